// File: doc/BRIEF.md
# Dual Down-Counter Timer with 64-bit Cascade

This peripheral holds two independent 32-bit down counters. Each one has its own interrupt output. Software reaches the counters through a simple register bus made of a word address, a write strobe, write data and combinational read data. Each counter runs in periodic mode or in one-shot mode. A counter moves only on cycles where the external count enable is high, so a prescaler outside the block sets the counting rate.

Setting bit 0 of the mode register joins the two timers into one 64-bit down counter. That counter has its own register set, and its interrupt appears on the first interrupt output. Each mode accepts writes only to its own register set. In 64-bit mode, writes to the 32-bit registers are dropped without any effect. In 32-bit mode, writes to the 64-bit registers are dropped in the same way. The mode register itself always accepts writes.

Word address map:

| Address | Register |
|---|---|
| 0 to 5 | Timer A: value (read-only), load, background load, control, raw status, masked status |
| 6 to 11 | Timer B: the same six registers in the same order |
| 12 | Mode |
| 13, 14 | 64-bit value high, low (read-only) |
| 15, 16 | 64-bit load high, low |
| 17, 18 | 64-bit background load high, low |
| 19, 20, 21 | 64-bit control, raw status, masked status |

Control bits are the same in every register set: bit 0 enable, bit 1 one-shot, bit 2 interrupt enable. Any unmapped address reads as zero.

Top module: `dual_dcnt_timer`

## Requirements
- R1: After reset, every address from 0 to 21 reads zero and both interrupt outputs are low.
- R2: A write to a load register stores the value and also loads it into the counter in the cycle after the write. A read of the load register returns the stored value.
- R3: An enabled counter (control bit 0 set) decrements by one only on cycles where cnt_en is high. While cnt_en is low, the value holds.
- R4: A tick that takes the counter from 1 to 0 sets that counter's raw status bit (bit 0 of the raw register).
- R5: In periodic mode (control bit 1 clear), a tick while the value is zero reloads the counter from the load register.
- R6: In one-shot mode (control bit 1 set), the counter stays at zero on later ticks until software writes a new load value.
- R7: A write to a background load register changes the reload value only. The running count is untouched, and the new value is used at the next reload.
- R8: The masked status and the interrupt output each equal the raw bit ANDed with control bit 2. Timer A drives irq0 and timer B drives irq1.
- R9: Writing 1 to bit 0 of a raw register clears it, and writing 0 leaves it set. If a zero-reaching tick falls in the same cycle as a clear, the bit stays set.
- R10: With mode bit 0 set, the 64-bit counter runs with a borrow across its halves. A write to the low half of its load register loads the counter from both halves. A write to the high half only stores that half. The two 32-bit timers do not count in this mode.
- R11: In 64-bit mode, writes to addresses 0 to 11 have no effect. In 32-bit mode, writes to addresses 13 to 21 have no effect.
- R12: If a load write and a tick fall in the same cycle, the counter takes the written value.
- R13: In 64-bit mode, irq0 carries the interrupt of the 64-bit counter and irq1 is held low. Returning to 32-bit mode restores the interrupt of timer B on irq1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count enable; one decrement per high cycle |
| we | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for addr (combinational) |
| irq0 | output | 1 | Interrupt of timer A, or of the 64-bit counter in cascade mode |
| irq1 | output | 1 | Interrupt of timer B; held low in cascade mode |

## Verification
Two kinds of operation can land in the same cycle. A zero-reaching tick can coincide with a software clear of the raw status. A tick can also coincide with a load write. The bench provokes both by raising cnt_en in the very cycle that carries the write. It then judges the result from the ports: the raw bit must still read 1, and the counter must read the written load value rather than a decremented one. Around these cases, a sweep over small load values and tick counts compares each read value with load minus ticks.

// File: rtl/dt_pkg.sv
// Shared definitions for the dual down-counter timer.
// Assumes word addressing; the offsets below are the software-visible map.
package dt_pkg;

    localparam int unsigned REGS_PER_UNIT = 6;
    localparam int unsigned OFS_VAL = 0;
    localparam int unsigned OFS_LD  = 1;
    localparam int unsigned OFS_BG  = 2;
    localparam int unsigned OFS_CTL = 3;
    localparam int unsigned OFS_RAW = 4;
    localparam int unsigned OFS_MSK = 5;

    localparam int unsigned NUM_NARROW = 2;
    localparam int unsigned ADR_MODE   = NUM_NARROW * REGS_PER_UNIT;
    localparam int unsigned ADR_W_VHI  = ADR_MODE + 1;
    localparam int unsigned ADR_W_VLO  = ADR_MODE + 2;
    localparam int unsigned ADR_W_LHI  = ADR_MODE + 3;
    localparam int unsigned ADR_W_LLO  = ADR_MODE + 4;
    localparam int unsigned ADR_W_BHI  = ADR_MODE + 5;
    localparam int unsigned ADR_W_BLO  = ADR_MODE + 6;
    localparam int unsigned ADR_W_CTL  = ADR_MODE + 7;
    localparam int unsigned ADR_W_RAW  = ADR_MODE + 8;
    localparam int unsigned ADR_W_MSK  = ADR_MODE + 9;

    localparam int unsigned CTL_W   = 3;
    localparam int unsigned CTL_EN  = 0;
    localparam int unsigned CTL_ONE = 1;
    localparam int unsigned CTL_IE  = 2;

    // Write strobes seen by one counter unit.
    typedef struct packed {
        logic ld;
        logic bg;
        logic ctl;
        logic clr;
    } unit_wr_t;

    // Write strobes of the 64-bit register set (split halves).
    typedef struct packed {
        logic ld_hi;
        logic ld_lo;
        logic bg_hi;
        logic bg_lo;
        logic ctl;
        logic clr;
    } wide_wr_t;

endpackage

// File: rtl/dt_wr_decode.sv
// Write decoder: turns a bus write into per-unit strobes.
// Gates the narrow set off in cascade mode and the wide set off in split mode,
// so dropped writes never reach any register. The mode register always decodes.
module dt_wr_decode
    import dt_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode_q,
    output unit_wr_t          nar_wr [NUM_NARROW],
    output wide_wr_t          wide_wr,
    output logic              mode_wr
);

    // Narrow units: one decoder slice per timer.
    for (genvar g = 0; g < NUM_NARROW; g++) begin : g_nar
        localparam int unsigned BASE = g * REGS_PER_UNIT;
        logic acc;
        assign acc = we && !mode_q;
        // Strobe map for timer g.
        always_comb begin
            nar_wr[g].ld  = acc && (addr == ADDR_W'(BASE + OFS_LD));
            nar_wr[g].bg  = acc && (addr == ADDR_W'(BASE + OFS_BG));
            nar_wr[g].ctl = acc && (addr == ADDR_W'(BASE + OFS_CTL));
            nar_wr[g].clr = acc && (addr == ADDR_W'(BASE + OFS_RAW));
        end
    end

    // Wide set strobes, live only in cascade mode.
    always_comb begin
        wide_wr.ld_hi = we && mode_q && (addr == ADDR_W'(ADR_W_LHI));
        wide_wr.ld_lo = we && mode_q && (addr == ADDR_W'(ADR_W_LLO));
        wide_wr.bg_hi = we && mode_q && (addr == ADDR_W'(ADR_W_BHI));
        wide_wr.bg_lo = we && mode_q && (addr == ADDR_W'(ADR_W_BLO));
        wide_wr.ctl   = we && mode_q && (addr == ADDR_W'(ADR_W_CTL));
        wide_wr.clr   = we && mode_q && (addr == ADDR_W'(ADR_W_RAW));
    end

    assign mode_wr = we && (addr == ADDR_W'(ADR_MODE));

endmodule

// File: rtl/dt_count_unit.sv
// One down counter with load, control and raw status registers.
// Assumes tick is already qualified by the block mode; the enable bit is applied here.
// Priority: load write beats tick; zero-reaching tick beats raw clear.
module dt_count_unit
    import dt_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  unit_wr_t         wr,
    input  logic [W-1:0]     ld_data,
    input  logic [CTL_W-1:0] ctl_data,
    input  logic             clr_bit,
    output logic [W-1:0]     value_q,
    output logic [W-1:0]     load_q,
    output logic [CTL_W-1:0] ctl_q,
    output logic             raw_q
);

    logic run;
    logic at_zero;
    logic hit_zero;

    assign run      = tick && ctl_q[CTL_EN];
    assign at_zero  = (value_q == '0);
    assign hit_zero = run && (value_q == W'(1)) && !wr.ld;

    // Counter: load, decrement, reload in periodic mode, hold in one-shot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (wr.ld) begin
            value_q <= ld_data;
        end else if (run) begin
            if (!at_zero) begin
                value_q <= value_q - W'(1);
            end else if (!ctl_q[CTL_ONE]) begin
                value_q <= load_q;
            end
        end
    end

    // Reload value, written by both the immediate and the background path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (wr.ld || wr.bg) begin
            load_q <= ld_data;
        end
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr.ctl) begin
            ctl_q <= ctl_data;
        end
    end

    // Raw status: set on reaching zero, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (hit_zero) begin
            raw_q <= 1'b1;
        end else if (wr.clr && clr_bit) begin
            raw_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dt_rd_mux.sv
// Read multiplexer: selects register contents for the current address.
// Purely combinational; unmapped addresses return zero.
module dt_rd_mux
    import dt_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]                      addr,
    input  logic                                   mode_q,
    input  logic [NUM_NARROW-1:0][CNT_W-1:0]       n_val,
    input  logic [NUM_NARROW-1:0][CNT_W-1:0]       n_load,
    input  logic [NUM_NARROW-1:0][CTL_W-1:0]       n_ctl,
    input  logic [NUM_NARROW-1:0]                  n_raw,
    input  logic [2*CNT_W-1:0]                     w_val,
    input  logic [2*CNT_W-1:0]                     w_load,
    input  logic [CTL_W-1:0]                       w_ctl,
    input  logic                                   w_raw,
    output logic [CNT_W-1:0]                       rdata
);

    // Address decode of all readable registers.
    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_NARROW; g++) begin
            if (addr == ADDR_W'(g * REGS_PER_UNIT + OFS_VAL)) rdata = n_val[g];
            if (addr == ADDR_W'(g * REGS_PER_UNIT + OFS_LD))  rdata = n_load[g];
            if (addr == ADDR_W'(g * REGS_PER_UNIT + OFS_BG))  rdata = n_load[g];
            if (addr == ADDR_W'(g * REGS_PER_UNIT + OFS_CTL)) rdata = CNT_W'(n_ctl[g]);
            if (addr == ADDR_W'(g * REGS_PER_UNIT + OFS_RAW)) rdata = CNT_W'(n_raw[g]);
            if (addr == ADDR_W'(g * REGS_PER_UNIT + OFS_MSK))
                rdata = CNT_W'(n_raw[g] & n_ctl[g][CTL_IE]);
        end
        if (addr == ADDR_W'(ADR_MODE))  rdata = CNT_W'(mode_q);
        if (addr == ADDR_W'(ADR_W_VHI)) rdata = w_val[2*CNT_W-1:CNT_W];
        if (addr == ADDR_W'(ADR_W_VLO)) rdata = w_val[CNT_W-1:0];
        if (addr == ADDR_W'(ADR_W_LHI)) rdata = w_load[2*CNT_W-1:CNT_W];
        if (addr == ADDR_W'(ADR_W_LLO)) rdata = w_load[CNT_W-1:0];
        if (addr == ADDR_W'(ADR_W_BHI)) rdata = w_load[2*CNT_W-1:CNT_W];
        if (addr == ADDR_W'(ADR_W_BLO)) rdata = w_load[CNT_W-1:0];
        if (addr == ADDR_W'(ADR_W_CTL)) rdata = CNT_W'(w_ctl);
        if (addr == ADDR_W'(ADR_W_RAW)) rdata = CNT_W'(w_raw);
        if (addr == ADDR_W'(ADR_W_MSK)) rdata = CNT_W'(w_raw & w_ctl[CTL_IE]);
    end

endmodule

// File: rtl/dual_dcnt_timer.sv
// Dual down-counter timer with optional 64-bit cascade.
// Two narrow units count in split mode; one double-width unit counts in cascade
// mode. The mode bit steers ticks, write acceptance and the interrupt outputs.
// Assumes a synchronous active-low reset and a single clock domain.
module dual_dcnt_timer
    import dt_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq0,
    output logic              irq1
);

    localparam int unsigned WW = 2 * CNT_W;

    logic                               mode_q;
    logic                               mode_wr;
    unit_wr_t                           nar_wr [NUM_NARROW];
    wide_wr_t                           wide_wr;
    unit_wr_t                           w_wr;
    logic [WW-1:0]                      w_ld_data;
    logic [NUM_NARROW-1:0][CNT_W-1:0]   n_val;
    logic [NUM_NARROW-1:0][CNT_W-1:0]   n_load;
    logic [NUM_NARROW-1:0][CTL_W-1:0]   n_ctl;
    logic [NUM_NARROW-1:0]              n_raw;
    logic [WW-1:0]                      w_val;
    logic [WW-1:0]                      w_load;
    logic [CTL_W-1:0]                   w_ctl;
    logic                               w_raw;
    logic                               tick_n;
    logic                               tick_w;

    // Mode register: bit 0 selects cascade operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (mode_wr) begin
            mode_q <= wdata[0];
        end
    end

    assign tick_n = cnt_en && !mode_q;
    assign tick_w = cnt_en && mode_q;

    dt_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .we      (we),
        .addr    (addr),
        .mode_q  (mode_q),
        .nar_wr  (nar_wr),
        .wide_wr (wide_wr),
        .mode_wr (mode_wr)
    );

    // Narrow timers, one per interrupt output.
    for (genvar g = 0; g < NUM_NARROW; g++) begin : g_unit
        dt_count_unit #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_n),
            .wr       (nar_wr[g]),
            .ld_data  (wdata),
            .ctl_data (wdata[CTL_W-1:0]),
            .clr_bit  (wdata[0]),
            .value_q  (n_val[g]),
            .load_q   (n_load[g]),
            .ctl_q    (n_ctl[g]),
            .raw_q    (n_raw[g])
        );
    end

    // Map half-word writes of the wide set onto full-width unit strobes.
    always_comb begin
        w_wr.ld  = wide_wr.ld_lo;
        w_wr.bg  = wide_wr.ld_hi || wide_wr.bg_hi || wide_wr.bg_lo;
        w_wr.ctl = wide_wr.ctl;
        w_wr.clr = wide_wr.clr;
        if (wide_wr.ld_hi || wide_wr.bg_hi) begin
            w_ld_data = {wdata, w_load[CNT_W-1:0]};
        end else begin
            w_ld_data = {w_load[WW-1:CNT_W], wdata};
        end
    end

    dt_count_unit #(.W(WW)) u_wide (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .wr       (w_wr),
        .ld_data  (w_ld_data),
        .ctl_data (wdata[CTL_W-1:0]),
        .clr_bit  (wdata[0]),
        .value_q  (w_val),
        .load_q   (w_load),
        .ctl_q    (w_ctl),
        .raw_q    (w_raw)
    );

    dt_rd_mux #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
        .addr   (addr),
        .mode_q (mode_q),
        .n_val  (n_val),
        .n_load (n_load),
        .n_ctl  (n_ctl),
        .n_raw  (n_raw),
        .w_val  (w_val),
        .w_load (w_load),
        .w_ctl  (w_ctl),
        .w_raw  (w_raw),
        .rdata  (rdata)
    );

    // Interrupt steering by mode.
    always_comb begin
        if (mode_q) begin
            irq0 = w_raw && w_ctl[CTL_IE];
            irq1 = 1'b0;
        end else begin
            irq0 = n_raw[0] && n_ctl[0][CTL_IE];
            irq1 = n_raw[1] && n_ctl[1][CTL_IE];
        end
    end

endmodule

// File: rtl/dt_timer_chk.sv
// Property checker for dual_dcnt_timer, attached by bind.
// Observes bus inputs and internal unit state; drives nothing.
module dt_timer_chk
    import dt_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 5
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              cnt_en,
    input logic                              we,
    input logic [ADDR_W-1:0]                 addr,
    input logic                              wbit0,
    input logic                              mode_q,
    input logic [CNT_W-1:0]                  a_val,
    input logic [CTL_W-1:0]                  a_ctl,
    input logic                              a_raw,
    input logic [NUM_NARROW-1:0][CNT_W-1:0]  n_load,
    input logic [2*CNT_W-1:0]                w_val,
    input logic [2*CNT_W-1:0]                w_load,
    input logic [CTL_W-1:0]                  w_ctl,
    input logic                              irq0
);

    logic a_ld_wr;
    assign a_ld_wr = we && (addr == ADDR_W'(OFS_LD));

    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && cnt_en && a_ctl[CTL_EN] && (a_val != '0) && !a_ld_wr)
        |=> (a_val == $past(a_val) - CNT_W'(1)));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !we) |=> ($stable(a_val) && $stable(w_val)));

    assert_oneshot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && a_ctl[CTL_EN] && a_ctl[CTL_ONE] && (a_val == '0) && !we)
        |=> (a_val == '0));

    assert_raw_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_raw && !(we && (addr == ADDR_W'(OFS_RAW)) && wbit0)) |=> a_raw);

    assert_drop_narrow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && we && (addr < ADDR_W'(ADR_MODE))) |=> ($stable(n_load) && $stable(a_ctl)));

    assert_drop_wide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && we && (addr > ADDR_W'(ADR_MODE)) && (addr <= ADDR_W'(ADR_W_MSK)))
        |=> ($stable(w_load) && $stable(w_ctl)));

    assert_irq_needs_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && irq0) |-> a_raw);

endmodule

bind dual_dcnt_timer dt_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .we     (we),
    .addr   (addr),
    .wbit0  (wdata[0]),
    .mode_q (mode_q),
    .a_val  (n_val[0]),
    .a_ctl  (n_ctl[0]),
    .a_raw  (n_raw[0]),
    .n_load (n_load),
    .w_val  (w_val),
    .w_load (w_load),
    .w_ctl  (w_ctl),
    .irq0   (irq0)
);

// File: tb/test_dual_dcnt_timer.sv
// Self-checking bench for dual_dcnt_timer: sweeps small loads and tick counts,
// then walks the priority, cascade and write-drop corner cases.
module test_dual_dcnt_timer;

    localparam int unsigned CW = 32;
    localparam int unsigned AW = 5;
    localparam logic [AW-1:0] A_VAL = 0, A_LD = 1, A_BG = 2, A_CTL = 3, A_RAW = 4, A_MSK = 5;
    localparam logic [AW-1:0] B_VAL = 6, B_LD = 7, B_CTL = 9, B_RAW = 10;
    localparam logic [AW-1:0] MODE = 12, W_VHI = 13, W_VLO = 14, W_LHI = 15, W_LLO = 16;
    localparam logic [AW-1:0] W_CTL = 19, W_RAW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic          irq0, irq1;

    int checks = 0;
    int failures = 0;
    logic [CW-1:0] rv, keep;

    always #10 clk = ~clk;

    dual_dcnt_timer #(.CNT_W(CW), .ADDR_W(AW)) i_dual_dcnt_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq0(irq0), .irq1(irq1)
    );

    task automatic check(input string tag, input logic [CW-1:0] got, input logic [CW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_en = 1'b1;
            @(negedge clk);
            cnt_en = 1'b0;
        end
    endtask

    // Write and tick in the same cycle.
    task automatic wr_tick(input logic [AW-1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1; cnt_en = 1'b1;
        @(negedge clk);
        we = 1'b0; cnt_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state across the whole map
        for (int a = 0; a < 22; a++) begin
            rd(AW'(a), rv);
            check("R1 reset read", rv, '0);
        end
        check("R1 irq0 reset", CW'(irq0), '0);
        check("R1 irq1 reset", CW'(irq1), '0);

        // R2/R3/R4/R5/R8: sweep loads and tick counts, periodic, interrupt on
        for (int l = 1; l <= 6; l++) begin
            for (int k = 0; k <= l; k++) begin
                wr(A_CTL, 0);
                wr(A_LD, CW'(l));
                rd(A_LD, rv);
                check("R2 load readback", rv, CW'(l));
                wr(A_RAW, 1);
                wr(A_CTL, 32'h5);
                tick(k);
                rd(A_VAL, rv);
                check("R3 value after ticks", rv, CW'(l - k));
                rd(A_RAW, rv);
                check("R4 raw at zero", rv, CW'(k == l));
                check("R8 irq0 follows raw", CW'(irq0), CW'(k == l));
                if (k == l) begin
                    tick(1);
                    rd(A_VAL, rv);
                    check("R5 periodic reload", rv, CW'(l));
                end
            end
        end

        // R6/R8: one-shot with interrupt disabled, then enabled
        for (int l = 1; l <= 4; l++) begin
            wr(A_CTL, 0);
            wr(A_LD, CW'(l));
            wr(A_RAW, 1);
            wr(A_CTL, 32'h3);
            tick(l + 3);
            rd(A_VAL, rv);
            check("R6 one-shot holds zero", rv, '0);
            rd(A_RAW, rv);
            check("R6 one-shot raw", rv, 1);
            rd(A_MSK, rv);
            check("R8 masked with ie off", rv, '0);
            check("R8 irq0 with ie off", CW'(irq0), '0);
        end
        wr(A_CTL, 32'h7);
        rd(A_MSK, rv);
        check("R8 masked with ie on", rv, 1);
        check("R8 irq0 with ie on", CW'(irq0), 1);

        // R9: write-one-to-clear
        wr(A_RAW, 0);
        rd(A_RAW, rv);
        check("R9 write 0 keeps raw", rv, 1);
        wr(A_RAW, 1);
        rd(A_RAW, rv);
        check("R9 write 1 clears raw", rv, '0);

        // R9: zero-reaching tick in the same cycle as a clear
        wr(A_CTL, 0);
        wr(A_LD, 1);
        wr(A_CTL, 32'h1);
        wr_tick(A_RAW, 1);
        rd(A_RAW, rv);
        check("R9 set beats clear", rv, 1);
        rd(A_VAL, rv);
        check("R9 value reached zero", rv, '0);

        // R12: load write and tick together
        wr(A_LD, 4);
        wr_tick(A_LD, 9);
        rd(A_VAL, rv);
        check("R12 load beats tick", rv, 9);

        // R7: background load
        wr(A_CTL, 0);
        wr(A_LD, 3);
        wr(A_CTL, 32'h1);
        wr(A_BG, 7);
        rd(A_VAL, rv);
        check("R7 bg leaves count", rv, 3);
        tick(3);
        rd(A_VAL, rv);
        check("R7 count reached zero", rv, '0);
        tick(1);
        rd(A_VAL, rv);
        check("R7 reload uses bg value", rv, 7);

        // R8: timer B drives irq1, timer A stays put while disabled
        wr(A_CTL, 0);
        rd(A_VAL, keep);
        wr(B_LD, 2);
        wr(B_CTL, 32'h5);
        tick(2);
        rd(B_VAL, rv);
        check("R8 timer B value", rv, '0);
        rd(B_RAW, rv);
        check("R8 timer B raw", rv, 1);
        check("R8 irq1 from timer B", CW'(irq1), 1);
        rd(A_VAL, rv);
        check("R3 disabled A holds", rv, keep);

        // R10/R11/R13: cascade mode
        wr(MODE, 1);
        check("R13 irq1 low in cascade", CW'(irq1), '0);
        rd(A_LD, keep);
        wr(A_LD, 32'h55);
        rd(A_LD, rv);
        check("R11 narrow write dropped", rv, keep);
        wr(B_RAW, 1);
        rd(B_RAW, rv);
        check("R11 narrow clear dropped", rv, 1);
        rd(A_VAL, keep);
        wr(W_LHI, 1);
        rd(W_VHI, rv);
        check("R10 high load no reload", rv, '0);
        wr(W_LLO, 2);
        rd(W_VHI, rv);
        check("R10 loaded high", rv, 1);
        rd(W_VLO, rv);
        check("R10 loaded low", rv, 2);
        wr(W_CTL, 32'h5);
        tick(3);
        rd(W_VHI, rv);
        check("R10 borrow high", rv, '0);
        rd(W_VLO, rv);
        check("R10 borrow low", rv, 32'hFFFF_FFFF);
        rd(A_VAL, rv);
        check("R10 narrow idle in cascade", rv, keep);
        wr(W_LHI, 0);
        wr(W_LLO, 2);
        tick(2);
        rd(W_RAW, rv);
        check("R13 wide raw", rv, 1);
        check("R13 irq0 from wide", CW'(irq0), 1);
        check("R13 irq1 still low", CW'(irq1), '0);

        // R11/R13: back to split mode
        wr(MODE, 0);
        check("R13 irq1 restored", CW'(irq1), 1);
        wr(W_LLO, 5);
        rd(W_LLO, rv);
        check("R11 wide write dropped", rv, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule